// File: doc/BRIEF.md
# Low-Power Mode Controller (Halt and Idle)

This block decides when a small microcontroller core sleeps and when it wakes. Software requests one of two low-power states by writing a bit in a port data register; the register logic hands the controller a one-cycle write strobe for each bit. In the deep state (halt) every clock domain is gated off. In the light state (idle) only the core and ordinary peripherals are gated. The oscillator, the watchdog and the idle timer keep running.

Each state has its own set of wake sources, and wake always returns the controller to the active state. Halt ends on a rising edge of the clock-output pin or on an event from the multi-line wakeup unit. Idle ends when bit 13 of the idle timer changes or on a wakeup-unit event. Each wakeup line has an enable bit and a polarity select. A configuration input can lock halt out completely. Reset always forces the active state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the mode after that edge is active (`mode_o` = 2'b00) and all five enable outputs are 1.
- R2: In active mode, with `halt_lock_i` low, a high `halt_wr_i` at a clock edge puts the block in halt (`mode_o` = 2'b10) after that edge.
- R3: With `halt_lock_i` high, `halt_wr_i` has no effect and the mode stays active.
- R4: In active mode, a high `idle_wr_i` alone puts the block in idle (`mode_o` = 2'b01) after that edge.
- R5: When both strobes are high in the same active cycle, halt wins if `halt_lock_i` is low; otherwise idle is entered.
- R6: Both write strobes are ignored while the block is in halt or idle.
- R7: In halt, `core_clk_en_o`, `periph_clk_en_o`, `wdog_clk_en_o`, `tmr_clk_en_o` and `osc_en_o` are all 0.
- R8: In idle, `core_clk_en_o` and `periph_clk_en_o` are 0, and `wdog_clk_en_o`, `tmr_clk_en_o` and `osc_en_o` are 1.
- R9: `clkout_pin_i` passes through a two-flop synchronizer. A 0-to-1 change applied before clock edge n leaves halt, and the mode reads active after edge n+2.
- R10: Each wake line `wk_line_i[i]` passes through a two-flop synchronizer. It wakes from halt or idle, active after edge n+2, only if `wk_en_i[i]` is 1 and the change matches `wk_rise_i[i]` (1 = 0-to-1, 0 = 1-to-0). A disabled line, or a change of the other polarity, has no effect.
- R11: A change of `t0_bit13_i` does not end halt, and a clock-pin rising edge does not end idle.
- R12: In idle, a change of `t0_bit13_i` presented before edge n makes the mode active after edge n. A change is detected by comparing the input with its value at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_wr_i | input | 1 | One-cycle strobe: software set the halt request bit |
| idle_wr_i | input | 1 | One-cycle strobe: software set the idle request bit |
| halt_lock_i | input | 1 | Configuration bit; 1 forbids halt |
| clkout_pin_i | input | 1 | Level of the clock-output pin (asynchronous) |
| wk_line_i | input | 8 | Wakeup event lines (asynchronous) |
| wk_en_i | input | 8 | Per-line wake enable |
| wk_rise_i | input | 8 | Per-line polarity: 1 rising, 0 falling |
| t0_bit13_i | input | 1 | Bit 13 of the idle timer |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| wdog_clk_en_o | output | 1 | Watchdog clock enable |
| tmr_clk_en_o | output | 1 | Idle timer clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| mode_o | output | 2 | 00 active, 01 idle, 10 halt |

## Verification
The hardest situations to reach are those where an out-of-place wake source arrives while the block is asleep: a timer toggle during halt, a clock-pin edge during idle, or a wrong-polarity or masked line edge. Each must leave the block asleep, and a real wake must then still work. Directed sequences enter each mode and present these sources one at a time. A long random phase keeps write strobes dense enough that the block spends many cycles in both modes while all wake inputs toggle freely. A cycle-accurate bench model checks every cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'b00,
        PM_IDLE   = 2'b01,
        PM_HALT   = 2'b10
    } pm_mode_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic wdog;
        logic tmr;
        logic osc;
    } pm_clk_en_t;

    typedef struct packed {
        logic mw_evt;   // qualified wakeup-line event
        logic ck_rise;  // synchronized clock-pin rising edge
        logic t0_tgl;   // idle timer bit changed
    } pm_wake_t;

    function automatic pm_clk_en_t pm_enables(pm_mode_e m);
        pm_clk_en_t e;
        e.core   = (m == PM_ACTIVE);
        e.periph = (m == PM_ACTIVE);
        e.wdog   = (m != PM_HALT);
        e.tmr    = (m != PM_HALT);
        e.osc    = (m != PM_HALT);
        return e;
    endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync
    import pwr_mode_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] line_i,
    input  logic [N_LINES-1:0] en_i,
    input  logic [N_LINES-1:0] rise_i,
    input  logic               ckpin_i,
    input  logic               t0_i,
    output pm_wake_t           wake_o
);
    localparam int LAST = SYNC_STAGES;

    logic [N_LINES-1:0] line_hit;
    logic [LAST:0]      ck_sh;
    logic               t0_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic [LAST:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[LAST-1:0], line_i[i]};
        end
        assign line_hit[i] = en_i[i] &
            (rise_i[i] ? (sh[LAST-1] & ~sh[LAST]) : (~sh[LAST-1] & sh[LAST]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sh <= '0;
            t0_q  <= 1'b0;
        end else begin
            ck_sh <= {ck_sh[LAST-1:0], ckpin_i};
            t0_q  <= t0_i;
        end
    end

    assign wake_o.mw_evt  = |line_hit;
    assign wake_o.ck_rise = ck_sh[LAST-1] & ~ck_sh[LAST];
    assign wake_o.t0_tgl  = t0_i ^ t0_q;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     halt_wr_i,
    input  logic     idle_wr_i,
    input  logic     halt_lock_i,
    input  pm_wake_t wake_i,
    output pm_mode_e mode_o
);
    pm_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PM_ACTIVE: begin
                if (halt_wr_i && !halt_lock_i) mode_d = PM_HALT;
                else if (idle_wr_i)            mode_d = PM_IDLE;
            end
            PM_HALT: if (wake_i.mw_evt || wake_i.ck_rise) mode_d = PM_ACTIVE;
            PM_IDLE: if (wake_i.mw_evt || wake_i.t0_tgl)  mode_d = PM_ACTIVE;
            default: mode_d = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_ACTIVE;
        else     mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_ACTIVE && halt_wr_i && !halt_lock_i) |=> mode_q == PM_HALT); // R2
    AST_HALT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_ACTIVE && halt_lock_i) |=> mode_q != PM_HALT); // R3
    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_ACTIVE && idle_wr_i && !(halt_wr_i && !halt_lock_i)) |=> mode_q == PM_IDLE); // R4
    AST_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
        (mode_q != PM_ACTIVE) |=> (mode_q == PM_ACTIVE || $stable(mode_q))); // R6
    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_HALT && (wake_i.ck_rise || wake_i.mw_evt)) |=> mode_q == PM_ACTIVE); // R9
    AST_HALT_DEAF_T0: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_HALT && !wake_i.ck_rise && !wake_i.mw_evt) |=> mode_q == PM_HALT); // R11
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_IDLE && wake_i.t0_tgl) |=> mode_q == PM_ACTIVE); // R12

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_wr_i,
    input  logic               idle_wr_i,
    input  logic               halt_lock_i,
    input  logic               clkout_pin_i,
    input  logic [N_LINES-1:0] wk_line_i,
    input  logic [N_LINES-1:0] wk_en_i,
    input  logic [N_LINES-1:0] wk_rise_i,
    input  logic               t0_bit13_i,
    output logic               core_clk_en_o,
    output logic               periph_clk_en_o,
    output logic               wdog_clk_en_o,
    output logic               tmr_clk_en_o,
    output logic               osc_en_o,
    output logic [1:0]         mode_o
);
    pm_wake_t   wake;
    pm_mode_e   mode;
    pm_clk_en_t en;

    pwr_wake_sync #(.N_LINES(N_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_i  (wk_line_i),
        .en_i    (wk_en_i),
        .rise_i  (wk_rise_i),
        .ckpin_i (clkout_pin_i),
        .t0_i    (t0_bit13_i),
        .wake_o  (wake)
    );

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .halt_wr_i   (halt_wr_i),
        .idle_wr_i   (idle_wr_i),
        .halt_lock_i (halt_lock_i),
        .wake_i      (wake),
        .mode_o      (mode)
    );

    assign en              = pm_enables(mode);
    assign core_clk_en_o   = en.core;
    assign periph_clk_en_o = en.periph;
    assign wdog_clk_en_o   = en.wdog;
    assign tmr_clk_en_o    = en.tmr;
    assign osc_en_o        = en.osc;
    assign mode_o          = mode;

    AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> !(osc_en_o || wdog_clk_en_o || core_clk_en_o)); // R7
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01) |-> (wdog_clk_en_o && tmr_clk_en_o && !core_clk_en_o)); // R8

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_wr = 0, idle_wr = 0, halt_lock = 0, ckpin = 0, t0 = 0;
    logic [NL-1:0] wk_line = '0, wk_en = '0, wk_rise = '0;
    logic core_en, per_en, wd_en, tm_en, osc_en;
    logic [1:0] mode;

    int n_checks = 0;
    int n_fail = 0;
    bit random_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk(clk), .rst(rst), .halt_wr_i(halt_wr), .idle_wr_i(idle_wr),
        .halt_lock_i(halt_lock), .clkout_pin_i(ckpin), .wk_line_i(wk_line),
        .wk_en_i(wk_en), .wk_rise_i(wk_rise), .t0_bit13_i(t0),
        .core_clk_en_o(core_en), .periph_clk_en_o(per_en), .wdog_clk_en_o(wd_en),
        .tmr_clk_en_o(tm_en), .osc_en_o(osc_en), .mode_o(mode)
    );

    // Reference model built from the requirements
    logic [1:0] m_mode;
    logic [NL-1:0] s1, s2, s3;
    logic c1, c2, c3, t0q;

    function automatic logic [4:0] exp_en(logic [1:0] m);
        // {core, periph, wdog, tmr, osc}
        if (m == 2'b10) return 5'b00000;
        if (m == 2'b01) return 5'b00111;
        return 5'b11111;
    endfunction

    function automatic logic line_evt(logic [NL-1:0] a, logic [NL-1:0] b,
                                      logic [NL-1:0] en, logic [NL-1:0] rs);
        return |(en & ((rs & a & ~b) | (~rs & ~a & b)));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 2'b00; s1 <= '0; s2 <= '0; s3 <= '0;
            c1 <= 0; c2 <= 0; c3 <= 0; t0q <= 0;
        end else begin
            s1 <= wk_line; s2 <= s1; s3 <= s2;
            c1 <= ckpin; c2 <= c1; c3 <= c2; t0q <= t0;
            case (m_mode)
                2'b00: if (halt_wr && !halt_lock) m_mode <= 2'b10;
                       else if (idle_wr) m_mode <= 2'b01;
                2'b10: if (line_evt(s2, s3, wk_en, wk_rise) || (c2 && !c3)) m_mode <= 2'b00;
                2'b01: if (line_evt(s2, s3, wk_en, wk_rise) || (t0 != t0q)) m_mode <= 2'b00;
                default: m_mode <= 2'b00;
            endcase
        end
    end

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b (time %0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_mode(string tag, logic [1:0] exp);
        check(tag, {mode, core_en, per_en, wd_en, tm_en, osc_en}, {exp, exp_en(exp)});
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr(logic h, logic i);
        halt_wr = h; idle_wr = i;
        tick(1);
        halt_wr = 0; idle_wr = 0;
    endtask

    // Every-cycle comparison during the random phase
    always @(negedge clk) begin
        if (random_phase && !rst)
            check_mode("R2 R4 R9 R10 R12 random", m_mode);
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        tick(3);
        rst = 0;
        check_mode("R1 reset state", 2'b00);

        halt_lock = 1; pulse_wr(1, 0);
        check_mode("R3 locked halt ignored", 2'b00);
        halt_lock = 0; pulse_wr(1, 0);
        check_mode("R2 halt entry", 2'b10);
        check_mode("R7 halt enables", 2'b10);
        pulse_wr(0, 1);
        check_mode("R6 write ignored in halt", 2'b10);
        t0 = 1; tick(3);
        check_mode("R11 timer toggle ignored in halt", 2'b10);
        ckpin = 1; tick(2);
        check_mode("R9 not yet awake", 2'b10);
        tick(1);
        check_mode("R9 clock pin wake", 2'b00);
        ckpin = 0;

        pulse_wr(0, 1);
        check_mode("R4 idle entry", 2'b01);
        check_mode("R8 idle enables", 2'b01);
        pulse_wr(1, 0);
        check_mode("R6 write ignored in idle", 2'b01);
        ckpin = 1; tick(4);
        check_mode("R11 clock pin ignored in idle", 2'b01);
        ckpin = 0; tick(3);
        t0 = 0; tick(1);
        check_mode("R12 timer toggle wake", 2'b00);

        pulse_wr(1, 1);
        check_mode("R5 halt wins", 2'b10);
        wk_en[3] = 1; wk_rise[3] = 1;
        wk_line[5] = 1; tick(4);
        check_mode("R10 disabled line ignored", 2'b10);
        wk_line[3] = 1; tick(3);
        check_mode("R10 rising wake", 2'b00);

        halt_lock = 1; pulse_wr(1, 1);
        check_mode("R5 locked gives idle", 2'b01);
        wk_line[3] = 0; tick(4);
        check_mode("R10 wrong polarity ignored", 2'b01);
        wk_rise[3] = 0; wk_line[3] = 1; tick(4);
        check_mode("R10 rising ignored when falling selected", 2'b01);
        wk_line[3] = 0; tick(3);
        check_mode("R10 falling wake", 2'b00);
        halt_lock = 0;

        rst = 1; tick(1);
        check_mode("R1 reset again", 2'b00);
        rst = 0;
        tick(1);
        random_phase = 1;
        for (int c = 0; c < 4000; c++) begin
            halt_wr   = ($urandom % 6) == 0;
            idle_wr   = ($urandom % 6) == 0;
            halt_lock = ($urandom % 4) == 0;
            if (($urandom % 12) == 0) ckpin = ~ckpin;
            if (($urandom % 20) == 0) t0 = ~t0;
            for (int k = 0; k < NL; k++)
                if (($urandom % 24) == 0) wk_line[k] = ~wk_line[k];
            if ((c % 50) == 0) begin
                wk_en   = NL'($urandom);
                wk_rise = NL'($urandom);
            end
            if (c == 2000) rst = 1;
            if (c == 2002) rst = 0;
            tick(1);
        end
        random_phase = 0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule